// File: doc/BRIEF.md
# Pin-Addressed I2C Port Register Target

This block is an I2C target that holds two 6-bit output-port registers and reports one 8-bit input-port value. It runs entirely on the system clock. SCL and SDA are brought in through synchronizers and oversampled, and START and STOP conditions are found from the sampled levels. The block never drives SCL. It pulls SDA low through an output enable and otherwise leaves the line released.

The target address is one of two fixed 7-bit codes, and the `addr_sel` pin picks which one. In a write, each data byte carries a destination code in bits 7:6 and a new 6-bit value in bits 5:0. An accepted value is held back for a configurable number of clock cycles, which stands in for a slow non-volatile store, and only then appears on its output. In a read, the block returns register A, then register B, then the input port, and keeps cycling in that order for as long as the master acknowledges. A NACK from the master ends the read.

Top module: `i2c_portreg_target`

## Requirements
- R1: After a STOP the block ignores bus activity until a START. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high.
- R2: The block acknowledges address 1001110 when `addr_sel`=1 and 0110111 when `addr_sel`=0. It acknowledges no other address. The R/W bit is the eighth bit sent, with 1 meaning read.
- R3: The general call address 0000000 is never acknowledged.
- R4: The block has no SCL output. `sda_oe` (1 means pull SDA low) changes only while SCL is low, and it is 0 after every STOP.
- R5: A read returns {00, register A}, then {00, register B}, then `port_in`, MSB first. If the master keeps acknowledging, the sequence wraps back to register A.
- R6: A master NACK ends a read. Reading does not change the registers, and every new read starts again at register A.
- R7: A write data byte whose bits 7:6 are 00 targets register A, and 01 targets register B. Bits 5:0 give the new value, and the byte is acknowledged.
- R8: A write data byte with bits 7:6 equal to 10 or 11 is acknowledged. It changes no register and does not raise `busy`.
- R9: After an accepted write, `busy` is high for exactly COMMIT_CYCLES clocks. The output keeps its old value during that time and takes the new value in the cycle `busy` falls.
- R10: A data byte that arrives while `busy` is high is not acknowledged and is discarded.
- R11: A repeated START in the middle of a transfer returns the block to address matching.
- R12: After reset, `out_a` and `out_b` are 0, and `busy` and `sda_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_sel | input | 1 | Picks which of the two target addresses is used |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| port_in | input | 8 | Input-port value, returned as the third read byte |
| out_a | output | 6 | Committed register A |
| out_b | output | 6 | Committed register B |
| busy | output | 1 | High while a write is being committed |

## Verification
The bench builds the block with COMMIT_CYCLES=600 instead of the default of one million. With that setting, a whole commit window can be watched and its length counted to the exact cycle. The window is also longer than one byte on the bus, so a second data byte sent in the same transfer is sure to arrive while the block is busy, which exercises the NACK case. The synchronizer depth stays at 2 and each SCL quarter period lasts 10 clocks. This leaves margin for the block to drive SDA before the master samples it.

// File: rtl/i2c_pr_pkg.sv
package i2c_pr_pkg;
  localparam int REG_W = 6;
  localparam logic [6:0] ADDR_SEL_HI = 7'b1001110;
  localparam logic [6:0] ADDR_SEL_LO = 7'b0110111;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } bus_st_t;

  function automatic logic [1:0] next_idx(input logic [1:0] i);
    return (i == 2'd2) ? 2'd0 : i + 2'd1;
  endfunction
endpackage

// File: rtl/i2c_pr_sync.sv
module i2c_pr_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= {STAGES{INIT}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_pr_regs.sv
module i2c_pr_regs
  import i2c_pr_pkg::*;
#(
  parameter int COMMIT_CYCLES = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_go,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_val,
  output logic [REG_W-1:0] val_a,
  output logic [REG_W-1:0] val_b,
  output logic             busy
);
  localparam int CW = $clog2(COMMIT_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(COMMIT_CYCLES);

  logic [CW-1:0]    remain;
  logic             pend_sel;
  logic [REG_W-1:0] pend_val;
  logic [REG_W-1:0] store [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain   <= '0;
      pend_sel <= 1'b0;
      pend_val <= '0;
      store[0] <= '0;
      store[1] <= '0;
    end else if (wr_go && remain == '0) begin
      remain   <= LOAD;
      pend_sel <= wr_sel;
      pend_val <= wr_val;
    end else if (remain != '0) begin
      remain <= remain - CW'(1);
      if (remain == CW'(1)) store[pend_sel] <= pend_val;
    end
  end

  assign val_a = store[0];
  assign val_b = store[1];
  assign busy  = (remain != '0);
endmodule

// File: rtl/i2c_pr_engine.sv
module i2c_pr_engine
  import i2c_pr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             addr_sel,
  input  logic [REG_W-1:0] rd_a,
  input  logic [REG_W-1:0] rd_b,
  input  logic [7:0]       rd_c,
  input  logic             busy,
  output logic             sda_oe,
  output logic             wr_go,
  output logic             wr_sel,
  output logic [REG_W-1:0] wr_val
);
  localparam logic [7-REG_W:0] PAD = '0;

  bus_st_t    st;
  logic       scl_q, sda_q;
  logic [3:0] cnt;
  logic [7:0] shr, tx;
  logic       rw, mack;
  logic [1:0] idx;

  logic       scl_rise, scl_fall, start_c, stop_c;
  logic [6:0] my_addr;
  logic [1:0] nidx;
  logic [7:0] byte0, byte_n;

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign my_addr  = addr_sel ? ADDR_SEL_HI : ADDR_SEL_LO;
  assign nidx     = next_idx(idx);
  assign byte0    = {PAD, rd_a};

  always_comb begin
    case (nidx)
      2'd0:    byte_n = byte0;
      2'd1:    byte_n = {PAD, rd_b};
      default: byte_n = rd_c;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      cnt    <= '0;
      shr    <= '0;
      tx     <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      idx    <= '0;
      sda_oe <= 1'b0;
      wr_go  <= 1'b0;
      wr_sel <= 1'b0;
      wr_val <= '0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      wr_go <= 1'b0;
      if (start_c) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              shr <= {shr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (shr[7:1] == my_addr) begin
                sda_oe <= 1'b1;
                rw     <= shr[0];
                st     <= ST_AACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              idx <= '0;
              if (rw) begin
                tx     <= byte0;
                sda_oe <= ~byte0[7];
                st     <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_WDAT;
              end
            end
          end
          ST_WDAT: begin
            if (scl_rise) begin
              shr <= {shr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (!busy) begin
                sda_oe <= 1'b1;
                st     <= ST_WACK;
                if (!shr[7]) begin
                  wr_go  <= 1'b1;
                  wr_sel <= shr[6];
                  wr_val <= shr[REG_W-1:0];
                end
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= ST_RACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                idx    <= nidx;
                tx     <= byte_n;
                sda_oe <= ~byte_n[7];
                cnt    <= '0;
                st     <= ST_RDAT;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_portreg_target.sv
module i2c_portreg_target
  import i2c_pr_pkg::*;
#(
  parameter int COMMIT_CYCLES = 1000000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_sel,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [7:0]       port_in,
  output logic [REG_W-1:0] out_a,
  output logic [REG_W-1:0] out_b,
  output logic             busy
);
  logic             scl_s, sda_s;
  logic             wr_go, wr_sel;
  logic [REG_W-1:0] wr_val;

  i2c_pr_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  i2c_pr_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

  i2c_pr_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .addr_sel(addr_sel), .rd_a(out_a), .rd_b(out_b), .rd_c(port_in),
    .busy(busy), .sda_oe(sda_oe), .wr_go(wr_go), .wr_sel(wr_sel),
    .wr_val(wr_val));

  i2c_pr_regs #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_sel(wr_sel),
    .wr_val(wr_val), .val_a(out_a), .val_b(out_b), .busy(busy));
endmodule

// File: rtl/i2c_pr_chk.sv
module i2c_pr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       busy,
  input logic       wr_go,
  input logic [5:0] out_a,
  input logic [5:0] out_b
);
  // R4
  oe_quiet_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3)) |-> $stable(sda_oe));

  // R9
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(out_a) && $stable(out_b)));

  // R9
  change_at_busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(out_a) && $stable(out_b)) |-> $fell(busy));

  // R9
  busy_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_go));

  // R10
  no_write_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> !busy);
endmodule

bind i2c_portreg_target i2c_pr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .busy(busy),
  .wr_go(wr_go), .out_a(out_a), .out_b(out_b));

// File: tb/sim_i2c_portreg_target.sv
`timescale 1ns/1ps
module sim_i2c_portreg_target;
  localparam int COMMIT = 600;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [7:0] port_in = 8'h00;
  logic sda_oe, busy;
  logic [5:0] out_a, out_b;
  logic sda_line;

  assign sda_line = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  i2c_portreg_target #(.COMMIT_CYCLES(COMMIT), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(m_scl),
    .sda_i(sda_line), .sda_oe(sda_oe), .port_in(port_in),
    .out_a(out_a), .out_b(out_b), .busy(busy));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int exp_a = 0, exp_b = 0;
  bit pend_a = 1'b0, pend_b = 1'b0;
  bit mon_en = 1'b0;
  int blen = 0, last_len = 0;
  bit busy_q = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference comparison of committed outputs (R9)
  always @(negedge clk) begin
    if (mon_en) begin
      if (!(pend_a && !busy)) check(out_a == exp_a[5:0], "R9 out_a vs model", out_a, exp_a);
      if (!(pend_b && !busy)) check(out_b == exp_b[5:0], "R9 out_b vs model", out_b, exp_b);
      if (busy) blen++;
      else if (busy_q) begin last_len = blen; blen = 0; end
      busy_q = busy;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b;    tick(Q);
    m_scl = 1'b1; tick(2 * Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic wait_commit(input bit is_b, input int newv);
    int guard = 0;
    while (!busy && guard < 5000) begin tick(1); guard++; end
    while (busy && guard < 5000) begin tick(1); guard++; end
    tick(1);
    check(last_len == COMMIT, "R9 busy length", last_len, COMMIT);
    if (is_b) begin
      check(out_b == newv[5:0], "R9 out_b after commit", out_b, newv);
      exp_b = newv; pend_b = 1'b0;
    end else begin
      check(out_a == newv[5:0], "R9 out_a after commit", out_a, newv);
      exp_a = newv; pend_a = 1'b0;
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // R12 reset state
    check(out_a == 6'd0, "R12 out_a reset", out_a, 0);
    check(out_b == 6'd0, "R12 out_b reset", out_b, 0);
    check(busy == 1'b0, "R12 busy reset", busy, 0);
    check(sda_oe == 1'b0, "R12 sda_oe reset", sda_oe, 0);
    mon_en = 1'b1;

    // R2 R7: write register A through the address for addr_sel=1
    i2c_start();
    send_byte(8'h9C, ack); check(ack, "R2 addr 1001110 ack", ack, 1);
    send_byte(8'h15, ack); check(ack, "R7 data to A ack", ack, 1);
    pend_a = 1'b1;
    i2c_stop();
    check(!sda_oe, "R4 released after stop", sda_oe, 0);
    wait_commit(1'b0, 'h15);

    // R7 R10: write B, then a second byte while busy
    i2c_start();
    send_byte(8'h9C, ack); check(ack, "R2 addr ack", ack, 1);
    send_byte(8'h6A, ack); check(ack, "R7 data to B ack", ack, 1);
    pend_b = 1'b1;
    send_byte(8'h01, ack); check(!ack, "R10 nack while busy", ack, 0);
    i2c_stop();
    wait_commit(1'b1, 'h2A);
    check(out_a == 6'h15, "R10 busy byte discarded", out_a, 'h15);

    // R8: select codes 10 and 11 are acked and ignored
    i2c_start();
    send_byte(8'h9C, ack);
    send_byte(8'hBF, ack); check(ack, "R8 sel 10 ack", ack, 1);
    send_byte(8'hC3, ack); check(ack, "R8 sel 11 ack", ack, 1);
    i2c_stop();
    tick(50);
    check(!busy, "R8 no busy", busy, 0);
    check(out_a == 6'h15 && out_b == 6'h2A, "R8 registers unchanged", {out_a, out_b}, {6'h15, 6'h2A});

    // R5: read order with wrap
    port_in = 8'hA5;
    i2c_start();
    send_byte(8'h9D, ack); check(ack, "R5 read addr ack", ack, 1);
    recv_byte(d, 1'b1); check(d == 8'h15, "R5 first byte A", d, 'h15);
    recv_byte(d, 1'b1); check(d == 8'h2A, "R5 second byte B", d, 'h2A);
    recv_byte(d, 1'b1); check(d == 8'hA5, "R5 third byte port", d, 'hA5);
    recv_byte(d, 1'b0); check(d == 8'h15, "R5 wrap to A", d, 'h15);
    i2c_stop();
    check(!sda_oe, "R4 released after read stop", sda_oe, 0);

    // R6: short read, then non-destructive repeat
    i2c_start();
    send_byte(8'h9D, ack);
    recv_byte(d, 1'b0); check(d == 8'h15, "R6 only A read", d, 'h15);
    i2c_stop();
    i2c_start();
    send_byte(8'h9D, ack); check(ack, "R6 reread ack", ack, 1);
    recv_byte(d, 1'b0); check(d == 8'h15, "R6 reread starts at A", d, 'h15);
    i2c_stop();
    check(out_a == 6'h15 && out_b == 6'h2A, "R6 read non-destructive", {out_a, out_b}, {6'h15, 6'h2A});

    // R2 R3: wrong and general call addresses
    i2c_start();
    send_byte(8'h6E, ack); check(!ack, "R2 other addr nack", ack, 0);
    i2c_stop();
    i2c_start();
    send_byte(8'h00, ack); check(!ack, "R3 general call nack", ack, 0);
    i2c_stop();

    // R2: addr_sel=0 swaps the address
    addr_sel = 1'b0;
    tick(4);
    i2c_start();
    send_byte(8'h9C, ack); check(!ack, "R2 hi addr nack when sel=0", ack, 0);
    i2c_stop();
    i2c_start();
    send_byte(8'h6E, ack); check(ack, "R2 addr 0110111 ack", ack, 1);
    send_byte(8'h07, ack); check(ack, "R7 write A via low addr", ack, 1);
    pend_a = 1'b1;
    i2c_stop();
    wait_commit(1'b0, 'h07);

    // R11: repeated START restarts address matching
    i2c_start();
    send_byte(8'h6E, ack); check(ack, "R11 first addr ack", ack, 1);
    i2c_start();
    send_byte(8'h6F, ack); check(ack, "R11 addr after rstart ack", ack, 1);
    recv_byte(d, 1'b0); check(d == 8'h07, "R11 read after rstart", d, 'h07);
    i2c_stop();

    // R1: no START after STOP means the address is ignored
    m_scl = 1'b0; tick(Q);
    send_byte(8'h6E, ack); check(!ack, "R1 no start no ack", ack, 0);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    check(!sda_oe, "R4 released idle", sda_oe, 0);
    tick(20);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule